// File: doc/BRIEF.md
# Serial Divide-by-Five Unit

This block divides an unsigned dividend by the constant five and returns both the quotient and the remainder, with no adder, subtractor or divider in the data path. A load pulse captures the dividend. The unit then walks the dividend one bit per clock, most significant bit first. A five-state remainder machine tracks the running value modulo five. On every step a small table reports whether five "fits" at that position, and that answer is the next quotient bit.

A down counter sequences the walk. While it runs, `busy` is high. After the final bit, `busy` drops and `done` pulses for one cycle. The quotient, the 3-bit remainder and a zero-remainder flag then hold their values until a later operation finishes. A design that must split a pixel count or address into groups of five can place this unit where a few cycles of latency per operation are acceptable.

Top module: `div5_serial`

## Requirements
- R1: While reset is applied and after it is released, `busy` and `done` are low, `quotient` and `remainder` are zero, and `rem_zero` is high.
- R2: A clock edge with `load` high captures `dividend`, and `busy` is high from the next cycle. Changes on `dividend` after that edge do not affect the result.
- R3: `done` rises exactly DW clock edges after the load edge, lasts one cycle, and is never high together with `busy`.
- R4: At `done`, `quotient` (DW-2 bits, unsigned) equals the integer quotient of the captured dividend by five, including for the all-ones dividend.
- R5: At `done`, `remainder` holds the dividend modulo five as a binary value from 000 to 100. Values above 100 never appear.
- R6: `rem_zero` is high exactly when `remainder` is zero.
- R7: `quotient`, `remainder` and `rem_zero` change only on the edge that completes an operation. They stay unchanged while idle and while a new operation is running.
- R8: A load while `busy` is high abandons the running operation with no `done` for it, and restarts on the new dividend with full DW-cycle latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load | input | 1 | Start pulse; captures `dividend` |
| dividend | input | DW | Unsigned dividend |
| busy | output | 1 | High while bits are being consumed |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | DW-2 | Dividend divided by five |
| remainder | output | 3 | Dividend modulo five, binary 0 to 4 |
| rem_zero | output | 1 | High when the remainder is zero |

## Verification
The bench builds the unit with DW set to 8, so the quotient is 6 bits wide. At that width every one of the 256 dividend values can be run in turn and compared with integer division and modulo by five. This covers every path through the remainder table and the all-ones boundary value. The short width also keeps the restart case cheap: a second load lands mid-walk, and the bench confirms that only the second result appears, at the full latency.

// File: rtl/div5_pkg.sv
package div5_pkg;

  // Remainder state; the encoding is the binary remainder value itself.
  typedef enum logic [2:0] {
    RS0 = 3'd0,
    RS1 = 3'd1,
    RS2 = 3'd2,
    RS3 = 3'd3,
    RS4 = 3'd4
  } rem_e;

  // New remainder after appending one dividend bit: (2*r + b) mod 5.
  function automatic rem_e rem_next(rem_e cur, logic b);
    rem_e nxt;
    case (cur)
      RS0:     nxt = b ? RS1 : RS0;
      RS1:     nxt = b ? RS3 : RS2;
      RS2:     nxt = b ? RS0 : RS4;
      RS3:     nxt = b ? RS2 : RS1;
      RS4:     nxt = b ? RS4 : RS3;
      default: nxt = RS0;
    endcase
    return nxt;
  endfunction

  // Quotient bit of the step: set when 2*r + b reaches five.
  function automatic logic quo_bit(rem_e cur, logic b);
    logic q;
    case (cur)
      RS2:     q = b;
      RS3:     q = 1'b1;
      RS4:     q = 1'b1;
      default: q = 1'b0;
    endcase
    return q;
  endfunction

endpackage

// File: rtl/div5_rst_sync.sv
module div5_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/div5_step.sv
module div5_step
  import div5_pkg::*;
(
  input  rem_e cur,
  input  logic bit_i,
  output rem_e nxt,
  output logic q_o
);

  always_comb begin
    nxt = rem_next(cur, bit_i);
    q_o = quo_bit(cur, bit_i);
  end

endmodule

// File: rtl/div5_ctrl.sv
module div5_ctrl #(
  parameter int DW = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy,
  output logic done,
  output logic step,
  output logic last
);

  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] CNT_INIT = CW'(DW);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    cnt_en = 1'b0;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = CNT_INIT;
      busy_d = 1'b1;
    end else if (busy_q) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - CNT_ONE;
      if (cnt_q == CNT_ONE) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign step = busy_q & ~load;
  assign last = busy_q & ~load & (cnt_q == CNT_ONE);

endmodule

// File: rtl/div5_datapath.sv
module div5_datapath
  import div5_pkg::*;
#(
  parameter int DW = 13,
  parameter int QW = DW - 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] dividend,
  input  logic          step,
  input  logic          last,
  output logic [QW-1:0] quotient,
  output logic [2:0]    remainder,
  output logic          rem_zero
);

  logic [DW-1:0] sh_q, sh_d;
  rem_e          st_q, st_d, st_n;
  logic [QW-1:0] qacc_q, qacc_d, qacc_shift;
  logic [QW-1:0] quo_q, quo_d;
  rem_e          rem_q, rem_d;
  logic          zero_q, zero_d;
  logic          qb;
  logic          walk_en;

  div5_step u_step (
    .cur   (st_q),
    .bit_i (sh_q[DW-1]),
    .nxt   (st_n),
    .q_o   (qb)
  );

  // Quotient accumulator shift; the variant depends on the quotient width.
  generate
    if (QW > 1) begin : g_wide
      assign qacc_shift = {qacc_q[QW-2:0], qb};
    end else begin : g_narrow
      assign qacc_shift = qb;
    end
  endgenerate

  always_comb begin
    walk_en = load | step;
    sh_d    = sh_q;
    st_d    = st_q;
    qacc_d  = qacc_q;
    quo_d   = quo_q;
    rem_d   = rem_q;
    zero_d  = zero_q;
    if (load) begin
      sh_d   = dividend;
      st_d   = RS0;
      qacc_d = '0;
    end else if (step) begin
      sh_d   = {sh_q[DW-2:0], 1'b0};
      st_d   = st_n;
      qacc_d = qacc_shift;
      if (last) begin
        quo_d  = qacc_shift;
        rem_d  = st_n;
        zero_d = (st_n == RS0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      st_q   <= RS0;
      qacc_q <= '0;
    end else if (walk_en) begin
      sh_q   <= sh_d;
      st_q   <= st_d;
      qacc_q <= qacc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q  <= '0;
      rem_q  <= RS0;
      zero_q <= 1'b1;
    end else if (last) begin
      quo_q  <= quo_d;
      rem_q  <= rem_d;
      zero_q <= zero_d;
    end
  end

  assign quotient  = quo_q;
  assign remainder = rem_q;
  assign rem_zero  = zero_q;

endmodule

// File: rtl/div5_serial.sv
module div5_serial #(
  parameter int DW = 13,
  parameter int QW = DW - 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] dividend,
  output logic          busy,
  output logic          done,
  output logic [QW-1:0] quotient,
  output logic [2:0]    remainder,
  output logic          rem_zero
);

  logic rst_sync_n;
  logic step;
  logic last;

  div5_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  div5_ctrl #(.DW(DW)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (load),
    .busy  (busy),
    .done  (done),
    .step  (step),
    .last  (last)
  );

  div5_datapath #(.DW(DW), .QW(QW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (load),
    .dividend  (dividend),
    .step      (step),
    .last      (last),
    .quotient  (quotient),
    .remainder (remainder),
    .rem_zero  (rem_zero)
  );

endmodule

// File: rtl/div5_serial_chk.sv
module div5_serial_chk #(
  parameter int DW = 13,
  parameter int QW = DW - 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load,
  input logic          busy,
  input logic          done,
  input logic [QW-1:0] quotient,
  input logic [2:0]    remainder,
  input logic          rem_zero
);

  localparam int CW = $clog2(DW + 1);

  logic [CW-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else if (load) begin
      lat_q <= '0;
    end else if (busy) begin
      lat_q <= lat_q + CW'(1);
    end
  end

  AST_BUSY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);                                                    // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                   // R3
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));                                                  // R3
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == CW'(DW)));                                      // R3
  AST_REM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    remainder <= 3'd4);                                                // R5
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rem_zero == (remainder == 3'd0));                                  // R6
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(quotient) && $stable(remainder) && $stable(rem_zero))); // R7
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (load && busy) |=> (busy && !done));                               // R8

endmodule

bind div5_serial div5_serial_chk #(.DW(DW), .QW(QW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .load      (load),
  .busy      (busy),
  .done      (done),
  .quotient  (quotient),
  .remainder (remainder),
  .rem_zero  (rem_zero)
);

// File: tb/div5_serial_test.sv
module div5_serial_test;

  localparam int DW = 8;
  localparam int QW = DW - 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load = 1'b0;
  logic [DW-1:0] dividend = '0;
  logic          busy;
  logic          done;
  logic [QW-1:0] quotient;
  logic [2:0]    remainder;
  logic          rem_zero;

  div5_serial #(.DW(DW)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .dividend  (dividend),
    .busy      (busy),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder),
    .rem_zero  (rem_zero)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int val;
    int lc;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  bit started = 1'b0;
  logic [QW-1:0] last_q = '0;
  logic [2:0]    last_r = '0;
  logic          last_z = 1'b1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver: start one operation, scramble the input afterwards, wait for result.
  task automatic drive(input int x);
    @(negedge clk);
    load     = 1'b1;
    dividend = DW'(x);
    sb.push_back('{x, cyc + 1});
    @(negedge clk);
    load     = 1'b0;
    dividend = DW'(~x);
    while (sb.size() != 0) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (started) begin
      if (done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R8", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk((cyc - e.lc) == DW, "R3", "latency", cyc - e.lc, DW);
          chk(busy == 1'b0, "R3", "busy at done", int'(busy), 0);
          chk(int'(quotient) == e.val / 5, "R4", "quotient",
              int'(quotient), e.val / 5);
          chk(int'(remainder) == e.val % 5, "R5", "remainder",
              int'(remainder), e.val % 5);
          chk(rem_zero == (e.val % 5 == 0), "R6", "rem_zero",
              int'(rem_zero), int'(e.val % 5 == 0));
        end
        last_q = quotient;
        last_r = remainder;
        last_z = rem_zero;
      end else begin
        if ((quotient != last_q) || (remainder != last_r) || (rem_zero != last_z))
          chk(1'b0, "R7", "result changed without done",
              int'(quotient), int'(last_q));
        if (sb.size() != 0 && cyc >= sb[0].lc)
          chk(busy == 1'b1, "R2", "busy after load", int'(busy), 1);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while reset is applied
    chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    chk(rem_zero == 1'b1, "R1", "rem_zero in reset", int'(rem_zero), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state after release
    chk(busy == 1'b0, "R1", "busy", int'(busy), 0);
    chk(done == 1'b0, "R1", "done", int'(done), 0);
    chk(quotient == '0, "R1", "quotient", int'(quotient), 0);
    chk(remainder == 3'd0, "R1", "remainder", int'(remainder), 0);
    chk(rem_zero == 1'b1, "R1", "rem_zero", int'(rem_zero), 1);
    started = 1'b1;

    // R4 R5 R6: every dividend value, all-ones included
    for (int x = 0; x < (1 << DW); x++) drive(x);

    // R8: restart mid-walk; only the second operand produces a result
    @(negedge clk);
    load     = 1'b1;
    dividend = DW'(199);
    @(negedge clk);
    load     = 1'b0;
    dividend = '0;
    repeat (2) @(negedge clk);
    drive(137);
    drive(255);

    // R7: idle hold after the last result
    repeat (5) @(negedge clk);
    chk(int'(quotient) == 51, "R7", "held quotient", int'(quotient), 51);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule